// File: doc/BRIEF.md
# SAR Converter Digital Control Front-End

This block is the digital half of a 12-bit sampling converter. It watches two active-low control pins, a chip select and a read/convert line. When both are low at the same moment it takes a sample and runs a conversion. The conversion lasts for a fixed number of clock cycles. During that time an active-low busy flag is held low. At the end the result is written into an output register. A plain input port supplies the sampled code and stands in for the analog core and its search logic.

The result is placed on a 16-pin parallel bus, split into an upper and a lower group of eight pins. The bus is enabled only while chip select is low and read/convert is high. A half-swap pin chooses which half of the word appears on which group, so a narrow host can fetch the word as two bytes. Tri-state is modelled as a data vector plus a per-pin output-enable vector.

Both control pins pass through a two-flop synchroniser before any decision is made. The half-swap pin acts on the bus at once.

Top module: `sar_ctrl_frontend`

## Requirements
- R1: While reset is held and on the cycle after it, `conv_busy_n` is 1, `result_stale` is 0, `bus_oe` is all zeros and `bus_q` is zero. The first read after reset shows a result of 0.
- R2: A conversion begins only when the synchronised `chip_sel_n` and `conv_rd_n` are both low. Either pin may be the last to fall. `conv_busy_n` falls at the third rising edge that samples both pins low. A single pin low alone never starts a conversion.
- R3: `conv_busy_n` stays low for exactly `CONV_CYCLES` cycles. The new result is already in the output register in the first cycle in which `conv_busy_n` is high again.
- R4: The result equals the `sample_in` value present at the edge where `conv_busy_n` falls. Later changes to `sample_in` have no effect on that result.
- R5: A start condition seen while `conv_busy_n` is low is dropped. The conversion length does not change, and no conversion follows from the dropped request.
- R6: If both control pins are still low when `conv_busy_n` returns high, a new conversion starts on the next edge, so `conv_busy_n` is high for one cycle only. That result carries `result_stale`=1. A result whose conversion began with any idle gap carries `result_stale`=0.
- R7: `bus_oe` is all ones when the synchronised `chip_sel_n` is 0 and `conv_rd_n` is 1. It is all zeros for every other combination, and then `bus_q` is zero. The enable follows the pins two rising edges later.
- R8: While a conversion runs with the bus enabled, the bus shows the previous result unchanged until `conv_busy_n` rises.
- R9: With `half_swap`=0, `bus_q[15:8]` carries result bits 11..4 and `bus_q[7:0]` carries bits 3..0 followed by four zeros. With `half_swap`=1 the two 8-bit groups trade places. The swap takes effect without a clock edge.
- R10: Results are 12-bit two's complement and are passed unchanged. 0x7FF reads as +2047, 0x000 as 0, 0xFFF as -1 and 0x800 as -2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low chip select |
| conv_rd_n | input | 1 | Low requests a conversion; high requests a read |
| half_swap | input | 1 | Swaps the contents of the two pin groups |
| sample_in | input | 12 | Code held at the start of a conversion |
| conv_busy_n | output | 1 | Low while a conversion is running |
| result_stale | output | 1 | Current result was converted without an acquisition gap |
| bus_q | output | 16 | Parallel bus data, upper group in bits 15..8 |
| bus_oe | output | 16 | Per-pin output enable for `bus_q` |

## Verification
The assertions assume that both control pins and `half_swap` change only between clock edges. This lets the three-edge start latency and the two-edge enable latency be checked with fixed look-backs. They also assume that `half_swap` does not move during a conversion while the bus holds the previous word. The bench drives every input on the falling clock edge and reads outputs there too. It changes `half_swap` only after a conversion has finished, and it steps all 4096 codes through a short conversion so that the layout and coding can be computed arithmetically.

// File: rtl/sarfe_pkg.sv
package sarfe_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_t;

  // Counter width able to hold values 0..limit
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/sarfe_sync.sv
module sarfe_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sarfe_sequencer.sv
module sarfe_sequencer
  import sarfe_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CONV_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy_n,
  output logic [DATA_W-1:0] res_q,
  output logic              res_stale
);

  localparam int CNT_W = cnt_width(CONV_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hold_q;
  logic              hold_stale_q;
  logic              just_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_IDLE;
      cnt_q        <= '0;
      hold_q       <= '0;
      hold_stale_q <= 1'b0;
      just_done_q  <= 1'b0;
      busy_n       <= 1'b1;
      res_q        <= '0;
      res_stale    <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          just_done_q <= 1'b0;
          if (start_req) begin
            state_q      <= SEQ_CONV;
            cnt_q        <= CNT_LOAD;
            hold_q       <= sample_in;
            // no idle cycle since the last finish: no fresh acquisition
            hold_stale_q <= just_done_q;
            busy_n       <= 1'b0;
          end
        end
        SEQ_CONV: begin
          if (cnt_q == '0) begin
            state_q     <= SEQ_IDLE;
            res_q       <= hold_q;
            res_stale   <= hold_stale_q;
            busy_n      <= 1'b1;
            just_done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sarfe_bus_steer.sv
module sarfe_bus_steer #(
  parameter int DATA_W = 12,
  parameter int GROUP_W = 8
) (
  input  logic [DATA_W-1:0]    res,
  input  logic                 swap,
  input  logic                 rd_en,
  output logic [2*GROUP_W-1:0] bus_q,
  output logic [2*GROUP_W-1:0] bus_oe
);

  localparam int LOW_W = DATA_W - GROUP_W;
  localparam int PAD_W = GROUP_W - LOW_W;

  logic [GROUP_W-1:0] word_hi;
  logic [GROUP_W-1:0] word_lo;

  assign word_hi = res[DATA_W-1 -: GROUP_W];

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_lo = {res[LOW_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign word_lo = res[LOW_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!rd_en) begin
      bus_q  = '0;
      bus_oe = '0;
    end else begin
      bus_oe = '1;
      bus_q  = swap ? {word_lo, word_hi} : {word_hi, word_lo};
    end
  end

endmodule

// File: rtl/sar_ctrl_frontend.sv
module sar_ctrl_frontend #(
  parameter int DATA_W = 12,
  parameter int GROUP_W = 8,
  parameter int CONV_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chip_sel_n,
  input  logic                 conv_rd_n,
  input  logic                 half_swap,
  input  logic [DATA_W-1:0]    sample_in,
  output logic                 conv_busy_n,
  output logic                 result_stale,
  output logic [2*GROUP_W-1:0] bus_q,
  output logic [2*GROUP_W-1:0] bus_oe
);

  logic [1:0]        ctl_s;
  logic              sel_s;
  logic              rc_s;
  logic              start_req;
  logic              rd_en;
  logic [DATA_W-1:0] res;

  sarfe_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({chip_sel_n, conv_rd_n}),
    .q    (ctl_s)
  );

  assign sel_s     = ctl_s[1];
  assign rc_s      = ctl_s[0];
  assign start_req = ~(sel_s | rc_s);
  assign rd_en     = ~sel_s & rc_s;

  sarfe_sequencer #(
    .DATA_W     (DATA_W),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .sample_in(sample_in),
    .busy_n   (conv_busy_n),
    .res_q    (res),
    .res_stale(result_stale)
  );

  sarfe_bus_steer #(
    .DATA_W (DATA_W),
    .GROUP_W(GROUP_W)
  ) u_steer (
    .res   (res),
    .swap  (half_swap),
    .rd_en (rd_en),
    .bus_q (bus_q),
    .bus_oe(bus_oe)
  );

endmodule

// File: rtl/sar_ctrl_frontend_chk.sv
module sar_ctrl_frontend_chk #(
  parameter int GROUP_W = 8,
  parameter int CONV_CYCLES = 400
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 chip_sel_n,
  input logic                 conv_rd_n,
  input logic                 half_swap,
  input logic                 conv_busy_n,
  input logic                 result_stale,
  input logic [2*GROUP_W-1:0] bus_q,
  input logic [2*GROUP_W-1:0] bus_oe
);

  localparam int LCW = $clog2(CONV_CYCLES + 2);

  logic [LCW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_cnt <= '0;
    else if (conv_busy_n)  low_cnt <= '0;
    else                   low_cnt <= low_cnt + LCW'(1);
  end

  // R1: reset leaves the block idle with the bus released
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (conv_busy_n && !result_stale && bus_oe == '0));

  // R2: busy only falls three edges after both pins were low
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_busy_n) |-> ($past(chip_sel_n, 3) == 1'b0 && $past(conv_rd_n, 3) == 1'b0));

  // R3, R5: busy low length is fixed regardless of requests during it
  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_busy_n) |-> (low_cnt == LCW'(CONV_CYCLES)));

  // R6: stale flag only changes to set together with a completion
  assert_stale_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_stale) |-> $rose(conv_busy_n));

  // R7: enable is all-or-nothing and a released bus carries zero
  assert_oe_whole_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe == '0) || (bus_oe == '1));

  assert_bus_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe == '0) |-> (bus_q == '0));

  assert_oe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe != '0) |-> ($past(chip_sel_n, 2) == 1'b0 && $past(conv_rd_n, 2) == 1'b1));

  // R8: previous word held on the bus while converting
  assert_prev_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_busy_n && !$past(conv_busy_n) && bus_oe[0] && $past(bus_oe[0]) && $stable(half_swap))
      |-> $stable(bus_q));

endmodule

bind sar_ctrl_frontend sar_ctrl_frontend_chk #(
  .GROUP_W    (GROUP_W),
  .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chip_sel_n  (chip_sel_n),
  .conv_rd_n   (conv_rd_n),
  .half_swap   (half_swap),
  .conv_busy_n (conv_busy_n),
  .result_stale(result_stale),
  .bus_q       (bus_q),
  .bus_oe      (bus_oe)
);

// File: tb/tb_sar_ctrl_frontend.sv
module tb_sar_ctrl_frontend;

  localparam int CONV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_sel_n = 1'b1;
  logic        conv_rd_n = 1'b1;
  logic        half_swap = 1'b0;
  logic [11:0] sample_in = '0;
  logic        conv_busy_n;
  logic        result_stale;
  logic [15:0] bus_q;
  logic [15:0] bus_oe;

  int errors = 0;
  int checks = 0;
  logic [11:0] prev_code;

  always #10 clk = ~clk;

  sar_ctrl_frontend #(
    .DATA_W(12), .GROUP_W(8), .CONV_CYCLES(CONV), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .conv_rd_n(conv_rd_n),
    .half_swap(half_swap), .sample_in(sample_in), .conv_busy_n(conv_busy_n),
    .result_stale(result_stale), .bus_q(bus_q), .bus_oe(bus_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] layout(input logic [11:0] v, input bit sw);
    int hi, lo;
    hi = int'(v) / 16;
    lo = (int'(v) % 16) * 16;
    return sw ? 16'(lo * 256 + hi) : 16'(hi * 256 + lo);
  endfunction

  task automatic do_conv(input logic [11:0] code);
    int sv;
    sample_in = code;
    conv_rd_n = 1'b0;
    tick(3);
    check(conv_busy_n == 1'b0, "R2", "busy after read/convert low", 32'(conv_busy_n), 0);
    conv_rd_n = 1'b1;
    sample_in = ~code;  // must not reach the result (R4)
    tick(CONV - 1);
    check(conv_busy_n == 1'b0, "R3", "busy still low at last cycle", 32'(conv_busy_n), 0);
    check(bus_q == layout(prev_code, 1'b0), "R8", "previous result during conversion",
          32'(bus_q), 32'(layout(prev_code, 1'b0)));
    tick(1);
    check(conv_busy_n == 1'b1, "R3", "busy high after conversion", 32'(conv_busy_n), 1);
    check(bus_q == layout(code, 1'b0) && bus_oe == 16'hFFFF, "R4", "new result, normal order",
          32'(bus_q), 32'(layout(code, 1'b0)));
    check(result_stale == 1'b0, "R6", "stale flag after idle gap", 32'(result_stale), 0);
    half_swap = 1'b1;
    #1;
    check(bus_q == layout(code, 1'b1), "R9", "swapped groups", 32'(bus_q),
          32'(layout(code, 1'b1)));
    half_swap = 1'b0;
    #1;
    if (code == 12'h7FF || code == 12'h000 || code == 12'hFFF || code == 12'h800) begin
      sv = (int'(code) >= 2048) ? int'(code) - 4096 : int'(code);
      check($signed({bus_q[15:8], bus_q[7:4]}) == 12'(sv), "R10", "two's complement code",
            32'({bus_q[15:8], bus_q[7:4]}), 32'(sv));
    end
    prev_code = code;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    tick(3);
    check(conv_busy_n == 1'b1 && result_stale == 1'b0, "R1", "busy/stale in reset",
          32'({conv_busy_n, result_stale}), 32'h2);
    check(bus_oe == 16'h0 && bus_q == 16'h0, "R1", "bus released in reset", 32'(bus_oe), 0);
    rst_n = 1'b1;
    chip_sel_n = 1'b0;
    tick(3);
    check(bus_oe == 16'hFFFF, "R7", "enable with select low, read high", 32'(bus_oe), 32'hFFFF);
    check(bus_q == 16'h0, "R1", "result cleared by reset", 32'(bus_q), 0);
    prev_code = 12'h000;

    // R2/R5: read/convert falls first, select starts; requests while busy dropped
    chip_sel_n = 1'b1;
    tick(2);
    sample_in = 12'h5A3;
    conv_rd_n = 1'b0;
    tick(4);
    check(conv_busy_n == 1'b1, "R2", "one pin low alone", 32'(conv_busy_n), 1);
    chip_sel_n = 1'b0;
    tick(3);
    check(conv_busy_n == 1'b0, "R2", "select falls last", 32'(conv_busy_n), 0);
    chip_sel_n = 1'b1;
    sample_in = 12'h0F0;
    tick(2);
    chip_sel_n = 1'b0;
    tick(2);
    chip_sel_n = 1'b1;
    tick(CONV - 5);
    check(conv_busy_n == 1'b0, "R5", "length unchanged by request", 32'(conv_busy_n), 0);
    tick(1);
    check(conv_busy_n == 1'b1, "R5", "ends on time", 32'(conv_busy_n), 1);
    tick(8);
    check(conv_busy_n == 1'b1, "R5", "no deferred conversion", 32'(conv_busy_n), 1);
    conv_rd_n = 1'b1;
    chip_sel_n = 1'b0;
    tick(3);
    check(bus_q == layout(12'h5A3, 1'b0), "R4", "sample at start edge kept",
          32'(bus_q), 32'(layout(12'h5A3, 1'b0)));
    prev_code = 12'h5A3;

    // R6: both pins held low through completion
    sample_in = 12'h321;
    conv_rd_n = 1'b0;
    tick(3);
    n = 0;
    while (conv_busy_n == 1'b0 && n < 100) begin tick(1); n++; end
    check(result_stale == 1'b0, "R6", "first result fresh", 32'(result_stale), 0);
    check(bus_oe == 16'h0, "R7", "bus off while both low", 32'(bus_oe), 0);
    sample_in = 12'hABC;
    tick(1);
    check(conv_busy_n == 1'b0, "R6", "immediate restart", 32'(conv_busy_n), 0);
    conv_rd_n = 1'b1;
    n = 0;
    while (conv_busy_n == 1'b0 && n < 100) begin tick(1); n++; end
    check(result_stale == 1'b1, "R6", "restart result flagged", 32'(result_stale), 1);
    check(bus_q == layout(12'hABC, 1'b0), "R6", "restart result value",
          32'(bus_q), 32'(layout(12'hABC, 1'b0)));
    prev_code = 12'hABC;
    tick(4);

    // R9/R10: every code through a full conversion
    for (int c = 0; c < 4096; c++) do_conv(12'(c));

    // R7: remaining pin combinations
    chip_sel_n = 1'b1; conv_rd_n = 1'b1;
    tick(3);
    check(bus_oe == 16'h0 && bus_q == 16'h0, "R7", "select high, read high", 32'(bus_oe), 0);
    chip_sel_n = 1'b1; conv_rd_n = 1'b0;
    tick(3);
    check(bus_oe == 16'h0 && bus_q == 16'h0, "R7", "select high, read low", 32'(bus_oe), 0);
    chip_sel_n = 1'b0; conv_rd_n = 1'b1;
    tick(1);
    check(bus_oe == 16'h0, "R7", "enable not before two edges", 32'(bus_oe), 0);
    tick(1);
    check(bus_oe == 16'hFFFF, "R7", "enable after two edges", 32'(bus_oe), 32'hFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule